// File: doc/BRIEF.md
# Memory-to-Network Transmit DMA

This engine moves a block of words from memory onto an on-chip network write port. Software supplies five values: a one-cycle start pulse, a 5-bit command code, a destination network address, a source byte address and a word count. The engine then reads the words through a pipelined memory master port that can stall and can return data with variable latency. It forwards them to the network port, putting the destination address in front of the data as a flagged first beat.

The network port can report full after any write. A small internal buffer absorbs returned read data while the port is blocked. New reads are throttled so that the buffer can never overflow. A done output is high while the engine is idle, and it rises again once the last beat has been consumed. A new start is only issued while done is high.

Top module: `mem_tx_dma`

## Requirements
- R1: While the active-low asynchronous reset is asserted, and after it is released, `tx_done` is 1 and both `mem_rd` and `net_we` are 0.
- R2: In the cycle after an accepted start, `tx_done` is 0. It stays 0 until every beat of the transfer has been consumed, and neither `net_we` nor `mem_rd` is high while `tx_done` is high.
- R3: The first consumed beat of a transfer has `net_addr_flag` = 1 and `net_data` equal to the configured destination address.
- R4: Each later beat of the transfer has `net_addr_flag` = 0 and carries one memory word, in read order. Exactly `cfg_len` data beats are written, for lengths from 1 to at least 63.
- R5: Exactly `cfg_len` reads are accepted. The first is at `cfg_src`, and each following read address is 4 bytes above the previous one.
- R6: A read is accepted only in a cycle where `mem_rd` = 1 and `mem_wait` = 0. While `mem_wait` is high, `mem_rd` and `mem_addr` are held.
- R7: Every consumed beat carries the configured command code on `net_cmd`.
- R8: A beat is consumed in a cycle where `net_we` = 1 and `net_full` = 0. While `net_full` blocks it, `net_we`, `net_addr_flag` and `net_data` hold. No word is lost or duplicated, however long full stays high.
- R9: The number of buffered words plus the number of reads still outstanding never exceeds the buffer depth, so a returned word is never pushed into a full buffer.
- R10: The transfer is correct whether read data returns one cycle or two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | One-cycle start pulse |
| cfg_cmd | input | 5 | Command code attached to every network write |
| cfg_dest | input | DATA_W | Destination network address |
| cfg_src | input | ADDR_W | Source byte address |
| cfg_len | input | LEN_W | Transfer length in words |
| tx_done | output | 1 | High while idle or finished |
| mem_addr | output | ADDR_W | Read byte address |
| mem_rd | output | 1 | Read request |
| mem_rdata | input | DATA_W | Returned read word |
| mem_wait | input | 1 | Memory stall; a read is accepted only when low |
| mem_rvalid | input | 1 | Marks a returned read word |
| net_we | output | 1 | Network write request |
| net_addr_flag | output | 1 | High on the address beat |
| net_data | output | DATA_W | Address or data beat |
| net_cmd | output | 5 | Command code |
| net_full | input | 1 | Network port cannot accept this cycle |

## Verification
A wrong read pointer or a miscounted remaining-read register shows on the very next accepted read, as an address outside the 4-byte step or as one read too many or too few. A broken credit count or buffer pointer shows up a few cycles later. It appears at the network port as a skipped, repeated or stale word, and it is caught as soon as that beat is consumed. Errors in the output register's hold logic become visible in the first blocked cycle, as a beat whose flag or data moves while full is high. A stuck state register shows up within one transfer, as done rising before the last beat or never rising at all.

// File: rtl/dma_tx_pkg.sv
package dma_tx_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} dma_state_e;

  localparam int unsigned WORD_BYTES = 4;

  function automatic logic [31:0] step_addr(input logic [31:0] a);
    return a + 32'(WORD_BYTES);
  endfunction

  function automatic logic may_issue(input int unsigned held,
                                     input int unsigned inflight,
                                     input int unsigned depth);
    return (held + inflight) < depth;
  endfunction

endpackage

// File: rtl/dma_tx_read_issuer.sv
module dma_tx_read_issuer
  import dma_tx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 3,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] src,
  input  logic [LEN_W-1:0]  len,
  input  logic [CNT_W-1:0]  held,
  input  logic              rvalid,
  input  logic              mem_wait,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CNT_W-1:0]  inflight
);

  logic [LEN_W-1:0]  reads_left;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;

  assign mem_rd   = (reads_left != '0) &&
                    may_issue(32'(held), 32'(inflight), 32'(DEPTH));
  assign accept   = mem_rd & ~mem_wait;
  assign mem_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reads_left <= '0;
      addr_q     <= '0;
      inflight   <= '0;
    end else begin
      if (launch) begin
        reads_left <= len;
        addr_q     <= src;
      end else if (accept) begin
        reads_left <= reads_left - 1'b1;
        addr_q     <= ADDR_W'(step_addr(32'(addr_q)));
      end
      case ({accept, rvalid})
        2'b10:   inflight <= inflight + 1'b1;
        2'b01:   inflight <= inflight - 1'b1;
        default: inflight <= inflight;
      endcase
    end
  end

endmodule

// File: rtl/dma_tx_word_buf.sv
module dma_tx_word_buf #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (32'(count) == DEPTH);
  assign rdata = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) slot[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/dma_tx_beat_sender.sv
module dma_tx_beat_sender #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              launch,
  input  logic [DATA_W-1:0] dest,
  input  logic [LEN_W-1:0]  len,
  input  logic              buf_empty,
  input  logic [DATA_W-1:0] buf_word,
  input  logic              net_full,
  output logic              buf_pop,
  output logic              net_we,
  output logic              net_addr_flag,
  output logic [DATA_W-1:0] net_data,
  output logic              finish
);

  logic             addr_pending;
  logic [LEN_W-1:0] data_left;
  logic             slot_free, load_addr, load_data;

  assign slot_free = ~net_we | ~net_full;
  assign load_addr = run & addr_pending & slot_free;
  assign load_data = run & ~addr_pending & slot_free & ~buf_empty & (data_left != '0);
  assign buf_pop   = load_data;
  assign finish    = run & ~addr_pending & (data_left == '0) & slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_pending  <= 1'b0;
      data_left     <= '0;
      net_we        <= 1'b0;
      net_addr_flag <= 1'b0;
      net_data      <= '0;
    end else if (launch) begin
      addr_pending <= 1'b1;
      data_left    <= len;
    end else begin
      if (load_addr) begin
        addr_pending  <= 1'b0;
        net_we        <= 1'b1;
        net_addr_flag <= 1'b1;
        net_data      <= dest;
      end else if (load_data) begin
        data_left     <= data_left - 1'b1;
        net_we        <= 1'b1;
        net_addr_flag <= 1'b0;
        net_data      <= buf_word;
      end else if (slot_free) begin
        net_we        <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mem_tx_dma.sv
module mem_tx_dma
  import dma_tx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BUF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic [4:0]        cfg_cmd,
  input  logic [DATA_W-1:0] cfg_dest,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [LEN_W-1:0]  cfg_len,
  output logic              tx_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_wait,
  input  logic              mem_rvalid,
  output logic              net_we,
  output logic              net_addr_flag,
  output logic [DATA_W-1:0] net_data,
  output logic [4:0]        net_cmd,
  input  logic              net_full
);

  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  dma_state_e        state;
  logic [4:0]        cmd_q;
  logic [DATA_W-1:0] dest_q;
  logic              launch, run, finish;

  // named internal events, observed by the bound checker
  logic              fifo_push, fifo_pop, fifo_empty, fifo_full_w;
  logic [CNT_W-1:0]  fifo_count, rd_outstanding;
  logic [DATA_W-1:0] fifo_word;

  assign run       = (state == ST_BUSY);
  assign launch    = cfg_start & ~run;
  assign tx_done   = ~run;
  assign net_cmd   = cmd_q;
  assign fifo_push = mem_rvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cmd_q  <= '0;
      dest_q <= '0;
    end else if (launch) begin
      state  <= ST_BUSY;
      cmd_q  <= cfg_cmd;
      dest_q <= cfg_dest;
    end else if (finish) begin
      state  <= ST_IDLE;
    end
  end

  dma_tx_read_issuer #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .DEPTH(BUF_DEPTH)
  ) u_issue (
    .clk(clk), .rst_n(rst_n), .launch(launch), .src(cfg_src), .len(cfg_len),
    .held(fifo_count), .rvalid(mem_rvalid), .mem_wait(mem_wait),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .inflight(rd_outstanding)
  );

  dma_tx_word_buf #(
    .W(DATA_W), .DEPTH(BUF_DEPTH), .CNT_W(CNT_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(mem_rdata),
    .pop(fifo_pop), .rdata(fifo_word), .count(fifo_count),
    .empty(fifo_empty), .full(fifo_full_w)
  );

  dma_tx_beat_sender #(
    .DATA_W(DATA_W), .LEN_W(LEN_W)
  ) u_send (
    .clk(clk), .rst_n(rst_n), .run(run), .launch(launch), .dest(dest_q),
    .len(cfg_len), .buf_empty(fifo_empty), .buf_word(fifo_word),
    .net_full(net_full), .buf_pop(fifo_pop), .net_we(net_we),
    .net_addr_flag(net_addr_flag), .net_data(net_data), .finish(finish)
  );

endmodule

// File: rtl/mem_tx_dma_checker.sv
module mem_tx_dma_checker #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int BUF_DEPTH = 4,
  parameter int CNT_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_done,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_wait,
  input logic              net_we,
  input logic              net_full,
  input logic              net_addr_flag,
  input logic [DATA_W-1:0] net_data,
  input logic              fifo_push,
  input logic              fifo_full_w,
  input logic [CNT_W-1:0]  fifo_count,
  input logic [CNT_W-1:0]  rd_outstanding
);

  always_comb begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (tx_done && !mem_rd && !net_we);
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!net_we && !mem_rd));

  assert_read_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_wait) |=> (mem_rd && $stable(mem_addr)));

  assert_beat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (net_we && net_full) |=> (net_we && $stable(net_addr_flag) && $stable(net_data)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !fifo_full_w);

  assert_credit_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((CNT_W+1)'(fifo_count) + (CNT_W+1)'(rd_outstanding)) <= (CNT_W+1)'(BUF_DEPTH));

endmodule

bind mem_tx_dma mem_tx_dma_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .mem_rd(mem_rd),
  .mem_addr(mem_addr), .mem_wait(mem_wait), .net_we(net_we),
  .net_full(net_full), .net_addr_flag(net_addr_flag), .net_data(net_data),
  .fifo_push(fifo_push), .fifo_full_w(fifo_full_w), .fifo_count(fifo_count),
  .rd_outstanding(rd_outstanding)
);

// File: tb/test_mem_tx_dma.sv
module test_mem_tx_dma;

  localparam int DW = 32, AW = 32, LW = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cfg_start = 1'b0;
  logic [4:0]    cfg_cmd = '0;
  logic [DW-1:0] cfg_dest = '0;
  logic [AW-1:0] cfg_src = '0;
  logic [LW-1:0] cfg_len = '0;
  logic          tx_done, mem_rd, mem_rvalid, net_we, net_addr_flag;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata, net_data;
  logic [4:0]    net_cmd;
  logic          mem_wait = 1'b1, net_full = 1'b0;

  always #2 clk = ~clk;

  mem_tx_dma i_mem_tx_dma (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_cmd(cfg_cmd),
    .cfg_dest(cfg_dest), .cfg_src(cfg_src), .cfg_len(cfg_len),
    .tx_done(tx_done), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_wait(mem_wait), .mem_rvalid(mem_rvalid),
    .net_we(net_we), .net_addr_flag(net_addr_flag), .net_data(net_data),
    .net_cmd(net_cmd), .net_full(net_full)
  );

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return 32'hC0DE_0000 ^ (a * 32'd7) ^ {a[7:0], 24'h0};
  endfunction

  // environment knobs
  int wait_pct = 0, full_pct = 0;
  bit lat_two = 1'b0;

  // memory model: one or two cycles of read latency
  logic          p1_v = 1'b0, p2_v = 1'b0;
  logic [DW-1:0] p1_d = '0, p2_d = '0;
  always @(posedge clk) begin
    p1_v <= rst_n && mem_rd && !mem_wait;
    p1_d <= word_at(mem_addr);
    p2_v <= p1_v;
    p2_d <= p1_d;
    mem_wait <= !rst_n || ($urandom_range(99, 0) < wait_pct);
    net_full <= rst_n && ($urandom_range(99, 0) < full_pct);
  end
  assign mem_rvalid = lat_two ? p2_v : p1_v;
  assign mem_rdata  = lat_two ? p2_d : p1_d;

  // scoreboard
  logic          exp_flag[$];
  logic [DW-1:0] exp_data[$];
  logic [AW-1:0] exp_raddr[$];
  logic [4:0]    cur_cmd = '0;
  int mon_chk = 0, mon_fail = 0, main_chk = 0, main_fail = 0;

  logic          held = 1'b0, held_flag = 1'b0;
  logic [DW-1:0] held_data = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        mon_chk++;
        if (!(net_we && net_addr_flag == held_flag && net_data == held_data)) begin
          mon_fail++;
          $display("FAIL R8 blocked beat moved: we=%b flag=%b data=%h exp flag=%b data=%h",
                   net_we, net_addr_flag, net_data, held_flag, held_data);
        end
      end
      held      <= net_we && net_full;
      held_flag <= net_addr_flag;
      held_data <= net_data;
      if (net_we && !net_full) begin
        mon_chk++;
        if (exp_flag.size() == 0) begin
          mon_fail++;
          $display("FAIL R4 extra beat: flag=%b data=%h exp none", net_addr_flag, net_data);
        end else begin
          logic          ef;
          logic [DW-1:0] ed;
          ef = exp_flag.pop_front();
          ed = exp_data.pop_front();
          if (net_addr_flag != ef || net_data != ed || net_cmd != cur_cmd) begin
            mon_fail++;
            $display("FAIL %s beat: flag=%b data=%h cmd=%b exp flag=%b data=%h cmd=%b (R7)",
                     ef ? "R3" : "R4", net_addr_flag, net_data, net_cmd, ef, ed, cur_cmd);
          end
        end
      end
      if (mem_rd && !mem_wait) begin
        mon_chk++;
        if (exp_raddr.size() == 0) begin
          mon_fail++;
          $display("FAIL R5 extra read: addr=%h exp none", mem_addr);
        end else begin
          logic [AW-1:0] ea;
          ea = exp_raddr.pop_front();
          if (mem_addr != ea) begin
            mon_fail++;
            $display("FAIL R5 read addr: addr=%h exp %h", mem_addr, ea);
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    main_chk++;
    if (!ok) begin
      main_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_xfer(input int len, input logic [31:0] src, input logic [31:0] dest,
                          input logic [4:0] cmd, input bit two, input int wp, input int fp);
    @(negedge clk);
    lat_two = two; wait_pct = wp; full_pct = fp; cur_cmd = cmd;
    exp_flag.push_back(1'b1); exp_data.push_back(dest);
    for (int i = 0; i < len; i++) begin
      exp_flag.push_back(1'b0);
      exp_data.push_back(word_at(src + 32'(4 * i)));
      exp_raddr.push_back(src + 32'(4 * i));
    end
    cfg_start = 1'b1; cfg_cmd = cmd; cfg_dest = dest; cfg_src = src; cfg_len = LW'(len);
    @(negedge clk);
    cfg_start = 1'b0;
    check(tx_done == 1'b0, "R2 done low after start", int'(tx_done), 0);
    while (!tx_done) @(negedge clk);
    check(exp_flag.size() == 0, "R4 beats left when done", exp_flag.size(), 0);
    check(exp_raddr.size() == 0, "R5 reads left when done", exp_raddr.size(), 0);
    repeat (3) @(negedge clk);
    check(tx_done && !net_we && !mem_rd, "R2 idle after transfer", int'(net_we), 0);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures",
               mon_chk + main_chk + 1, mon_fail + main_fail + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tx_done && !mem_rd && !net_we, "R1 during reset", int'(tx_done), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tx_done && !mem_rd && !net_we, "R1 after reset", int'(tx_done), 1);
    run_xfer(1,  32'h0000_1000, 32'h0000_FFFF, 5'b00010, 1'b0, 0,  0);   // R3 R4 basic
    run_xfer(2,  32'h0000_2004, 32'h1234_5678, 5'b10001, 1'b1, 0,  0);   // R10 latency two
    run_xfer(7,  32'h0000_3000, 32'h0000_0042, 5'b00111, 1'b0, 50, 0);   // R6 stalls
    run_xfer(9,  32'h0000_4000, 32'h0000_0043, 5'b01010, 1'b1, 30, 70);  // R8 R9 full-heavy
    run_xfer(63, 32'h0001_0000, 32'hDEAD_BEEF, 5'b11111, 1'b0, 20, 40);  // R4 long
    run_xfer(63, 32'h0002_0100, 32'h0BAD_F00D, 5'b00001, 1'b1, 60, 90);  // R9 R10
    run_xfer(16, 32'h0003_0000, 32'h0000_0077, 5'b01100, 1'b0, 0,  95);  // R8 nearly always full
    run_xfer(3,  32'h0004_0008, 32'h0000_0078, 5'b00011, 1'b1, 90, 10);  // R6 long stalls
    $display("End of test - %0d assertions evaluated, %0d failures",
             mon_chk + main_chk, mon_fail + main_fail);
    $finish;
  end

endmodule